// File: doc/BRIEF.md
# Descriptor Ring Copy Engine

This block copies data from one region of memory to another on behalf of software. Work is described by two rings of descriptors that live in shared memory. A source ring entry names where the data comes from and how many bytes to move. A destination ring entry names where the data goes. Each ring has a base register, a fixed entry count, a software index and a hardware index, and all of them sit on a small register port.

Software fills source descriptors and then moves the source software index forward. It hands empty destination entries to the engine by writing the last recycled position into the destination software index. The engine then takes one source entry and one destination entry. It reads both descriptors and copies the payload one 32-bit word at a time over a synchronous memory port. It then writes a done flag and the length it moved into the destination descriptor, and steps both hardware indices on by one, wrapping at the ring depth.

A global control register enables each direction and write-back, and shows a busy flag for each direction. A reset register clears the indices of either ring and stops any descriptor in flight.

Top module: `ring_copy_engine`

## Requirements
- R1: After reset, every register reads 0, except the two count registers, which read RING_DEPTH. No memory request is issued.
- R2: Register offsets for the source ring are base 0x000, count 0x004, software index 0x008 and hardware index 0x00C. The destination ring uses the same layout at 0x100, 0x104, 0x108 and 0x10C. Base registers always read 0 in bits 1:0. A software index keeps only log2(RING_DEPTH) bits. Writes to a count register or a hardware index register have no effect.
- R3: The control register at 0x204 holds source enable in bit 0, destination enable in bit 2, a burst field in bits 5:4, write-back enable in bit 6 and a multi-mode flag in bit 10, and reads them back as written. Bit 1 (source busy) and bit 3 (destination busy) are read-only.
- R4: A descriptor starts only when both enables are set, the source hardware index differs from the source software index, and the destination hardware index differs from the destination software index.
- R5: Entry i of a ring is at base + 16*i. The source address is word 0 of the source descriptor. The length in bytes is bits 29:16 of word 1 of the source descriptor. The destination address is word 0 of the destination descriptor.
- R6: The engine copies ceil(length/4) words in increasing address order and writes nothing past them. A length of 0 copies no data.
- R7: A length field above 0x3F80 is treated as 0x3F80, both for the copy and for the reported length.
- R8: With write-back enabled, after the last data word the engine writes word 1 of the destination descriptor as bit 31 = 1 (done), bits 29:16 = the length, and all other bits 0. With write-back disabled, that word is left untouched.
- R9: Each finished descriptor advances both hardware indices by one, and an index wraps from RING_DEPTH-1 to 0.
- R10: Source busy is 1 during the source descriptor fetch and the copy. Destination busy is 1 during the destination descriptor fetch, the copy and the write-back. Both read 0 when the engine is idle.
- R11: Writing the reset register at 0x208 with bit 0 set clears both source indices, and with bit 16 set clears both destination indices. Either one abandons the descriptor in flight without a write-back.
- R12: The memory port carries at most one access per cycle. Read data is valid in the cycle after the request, and each copied word is written in the cycle its read data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid the cycle after a read request |

## Verification
Register reads are combinational, and a register write takes effect at the next clock edge. The bench therefore drives on the falling edge and samples half a cycle later. A descriptor begins one cycle after its start condition holds. It then takes six cycles of descriptor fetch, two cycles per copied word and one write-back cycle, and the hardware indices change on the write-back edge. Because that total depends on the length, the bench polls the destination hardware index for a bounded time before it checks memory. Checks that something does not happen (gating, abort) wait well past the longest due time before sampling. The busy check samples twelve cycles after enabling, which falls inside a sixteen-word copy.

// File: rtl/rce_pkg.sv
package rce_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_SRC_BASE = 12'h000;
    localparam logic [REG_AW-1:0] OFS_SRC_CNT  = 12'h004;
    localparam logic [REG_AW-1:0] OFS_SRC_SW   = 12'h008;
    localparam logic [REG_AW-1:0] OFS_SRC_HW   = 12'h00C;
    localparam logic [REG_AW-1:0] OFS_DST_BASE = 12'h100;
    localparam logic [REG_AW-1:0] OFS_DST_CNT  = 12'h104;
    localparam logic [REG_AW-1:0] OFS_DST_SW   = 12'h108;
    localparam logic [REG_AW-1:0] OFS_DST_HW   = 12'h10C;
    localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h204;
    localparam logic [REG_AW-1:0] OFS_CLEAR    = 12'h208;

    localparam int LEN_W    = 14;
    localparam int LEN_LSB  = 16;
    localparam int DONE_BIT = 31;
    localparam logic [LEN_W-1:0] LEN_CAP = 14'h3F80;
    localparam int WCNT_W   = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SD0,
        ST_SD0W,
        ST_SD1,
        ST_SD1W,
        ST_DD0,
        ST_DD0W,
        ST_CRD,
        ST_CRDW,
        ST_WB
    } eng_state_e;

endpackage

// File: rtl/rce_ring_ptr.sv
module rce_ring_ptr #(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic [31:0]   base_i,
    output logic [IW-1:0] idx_o,
    output logic [31:0]   desc_addr_o
);

    typedef struct packed {
        logic [IW-1:0] idx;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.idx = '0;
        end else if (adv_i) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o       = st_q.idx;
    assign desc_addr_o = base_i + {{(28-IW){1'b0}}, st_q.idx, 4'b0000};

    // R9: one step per finished descriptor, wrapping at the ring depth
    p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> (idx_o == $past(idx_o) + 1'b1));

    // R11: a clear request zeroes the hardware index
    p_idx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (idx_o == '0));

endmodule

// File: rtl/rce_regs.sv
module rce_regs
    import rce_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [IW-1:0]     src_hw_i,
    input  logic [IW-1:0]     dst_hw_i,
    input  logic              src_busy_i,
    input  logic              dst_busy_i,
    output logic [31:0]       src_base_o,
    output logic [31:0]       dst_base_o,
    output logic [IW-1:0]     src_sw_o,
    output logic [IW-1:0]     dst_sw_o,
    output logic              src_en_o,
    output logic              dst_en_o,
    output logic              wb_en_o,
    output logic              src_clr_o,
    output logic              dst_clr_o
);

    typedef struct packed {
        logic [29:0]   src_base;
        logic [29:0]   dst_base;
        logic [IW-1:0] src_sw;
        logic [IW-1:0] dst_sw;
        logic          src_en;
        logic          dst_en;
        logic [1:0]    burst;
        logic          wb_en;
        logic          multi;
    } regs_t;

    regs_t st_d, st_q;

    assign src_clr_o = wr_i && (addr_i == OFS_CLEAR) && wdata_i[0];
    assign dst_clr_o = wr_i && (addr_i == OFS_CLEAR) && wdata_i[16];

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            case (addr_i)
                OFS_SRC_BASE: st_d.src_base = wdata_i[31:2];
                OFS_DST_BASE: st_d.dst_base = wdata_i[31:2];
                OFS_SRC_SW:   st_d.src_sw   = wdata_i[IW-1:0];
                OFS_DST_SW:   st_d.dst_sw   = wdata_i[IW-1:0];
                OFS_CTRL: begin
                    st_d.src_en = wdata_i[0];
                    st_d.dst_en = wdata_i[2];
                    st_d.burst  = wdata_i[5:4];
                    st_d.wb_en  = wdata_i[6];
                    st_d.multi  = wdata_i[10];
                end
                default: ;
            endcase
        end
        if (src_clr_o) st_d.src_sw = '0;
        if (dst_clr_o) st_d.dst_sw = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_SRC_BASE: rdata_o = {st_q.src_base, 2'b00};
            OFS_DST_BASE: rdata_o = {st_q.dst_base, 2'b00};
            OFS_SRC_CNT,
            OFS_DST_CNT:  rdata_o = 32'(DEPTH);
            OFS_SRC_SW:   rdata_o = {{(32-IW){1'b0}}, st_q.src_sw};
            OFS_DST_SW:   rdata_o = {{(32-IW){1'b0}}, st_q.dst_sw};
            OFS_SRC_HW:   rdata_o = {{(32-IW){1'b0}}, src_hw_i};
            OFS_DST_HW:   rdata_o = {{(32-IW){1'b0}}, dst_hw_i};
            OFS_CTRL: begin
                rdata_o[0]   = st_q.src_en;
                rdata_o[1]   = src_busy_i;
                rdata_o[2]   = st_q.dst_en;
                rdata_o[3]   = dst_busy_i;
                rdata_o[5:4] = st_q.burst;
                rdata_o[6]   = st_q.wb_en;
                rdata_o[10]  = st_q.multi;
            end
            default: rdata_o = '0;
        endcase
    end

    assign src_base_o = {st_q.src_base, 2'b00};
    assign dst_base_o = {st_q.dst_base, 2'b00};
    assign src_sw_o   = st_q.src_sw;
    assign dst_sw_o   = st_q.dst_sw;
    assign src_en_o   = st_q.src_en;
    assign dst_en_o   = st_q.dst_en;
    assign wb_en_o    = st_q.wb_en;

    // R11: clearing a side zeroes its software index
    p_sw_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (src_clr_o || dst_clr_o) |=> ((!$past(src_clr_o) || src_sw_o == '0) &&
                                       (!$past(dst_clr_o) || dst_sw_o == '0)));

    // R2: a software index changes only through a register write or a clear
    p_sw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(src_sw_o) && $stable(dst_sw_o));

endmodule

// File: rtl/rce_engine.sv
module rce_engine
    import rce_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_en_i,
    input  logic          dst_en_i,
    input  logic          wb_en_i,
    input  logic          abort_i,
    input  logic [IW-1:0] src_hw_i,
    input  logic [IW-1:0] src_sw_i,
    input  logic [IW-1:0] dst_hw_i,
    input  logic [IW-1:0] dst_sw_i,
    input  logic [31:0]   src_desc_i,
    input  logic [31:0]   dst_desc_i,
    output logic          adv_o,
    output logic          src_busy_o,
    output logic          dst_busy_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [31:0]   mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic [31:0]   mem_rdata_i
);

    typedef struct packed {
        eng_state_e        st;
        logic [31:0]       src_ptr;
        logic [31:0]       dst_ptr;
        logic [LEN_W-1:0]  len;
        logic [WCNT_W-1:0] words;
    } eng_t;

    eng_t st_d, st_q;

    logic             can_start;
    logic [LEN_W-1:0] len_raw;
    logic [LEN_W-1:0] len_cut;

    assign can_start = src_en_i && dst_en_i &&
                       (src_hw_i != src_sw_i) && (dst_hw_i != dst_sw_i);
    assign len_raw   = mem_rdata_i[LEN_LSB +: LEN_W];
    assign len_cut   = (len_raw > LEN_CAP) ? LEN_CAP : len_raw;

    always_comb begin
        st_d        = st_q;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        adv_o       = 1'b0;
        case (st_q.st)
            ST_IDLE: if (can_start) st_d.st = ST_SD0;
            ST_SD0: begin
                mem_req_o  = 1'b1;
                mem_addr_o = src_desc_i;
                st_d.st    = ST_SD0W;
            end
            ST_SD0W: begin
                st_d.src_ptr = mem_rdata_i;
                st_d.st      = ST_SD1;
            end
            ST_SD1: begin
                mem_req_o  = 1'b1;
                mem_addr_o = src_desc_i + 32'd4;
                st_d.st    = ST_SD1W;
            end
            ST_SD1W: begin
                st_d.len   = len_cut;
                st_d.words = WCNT_W'(({1'b0, len_cut} + 15'd3) >> 2);
                st_d.st    = ST_DD0;
            end
            ST_DD0: begin
                mem_req_o  = 1'b1;
                mem_addr_o = dst_desc_i;
                st_d.st    = ST_DD0W;
            end
            ST_DD0W: begin
                st_d.dst_ptr = mem_rdata_i;
                st_d.st      = (st_q.words == '0) ? ST_WB : ST_CRD;
            end
            ST_CRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = st_q.src_ptr;
                st_d.st    = ST_CRDW;
            end
            ST_CRDW: begin
                mem_req_o    = 1'b1;
                mem_we_o     = 1'b1;
                mem_addr_o   = st_q.dst_ptr;
                mem_wdata_o  = mem_rdata_i;
                st_d.src_ptr = st_q.src_ptr + 32'd4;
                st_d.dst_ptr = st_q.dst_ptr + 32'd4;
                st_d.words   = st_q.words - 1'b1;
                st_d.st      = (st_q.words == WCNT_W'(1)) ? ST_WB : ST_CRD;
            end
            ST_WB: begin
                if (wb_en_i) begin
                    mem_req_o   = 1'b1;
                    mem_we_o    = 1'b1;
                    mem_addr_o  = dst_desc_i + 32'd4;
                    mem_wdata_o = '0;
                    mem_wdata_o[DONE_BIT] = 1'b1;
                    mem_wdata_o[LEN_LSB +: LEN_W] = st_q.len;
                end
                adv_o   = 1'b1;
                st_d.st = ST_IDLE;
            end
            default: st_d.st = ST_IDLE;
        endcase
        if (abort_i) begin
            st_d.st   = ST_IDLE;
            mem_req_o = 1'b0;
            mem_we_o  = 1'b0;
            adv_o     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        src_busy_o = 1'b0;
        dst_busy_o = 1'b0;
        case (st_q.st)
            ST_SD0, ST_SD0W, ST_SD1, ST_SD1W: src_busy_o = 1'b1;
            ST_DD0, ST_DD0W, ST_WB:           dst_busy_o = 1'b1;
            ST_CRD, ST_CRDW: begin
                src_busy_o = 1'b1;
                dst_busy_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R4: the first descriptor fetch follows a cycle where work was available
    p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_SD0) |-> $past(can_start && !abort_i));

    // R12: a write is always a request
    p_write_is_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);

    // R12: each copy write comes the cycle after a read request
    p_copy_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_CRDW) |-> $past(mem_req_o && !mem_we_o));

    // R10: the engine is busy on some side whenever it uses the memory port
    p_busy_on_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (src_busy_o || dst_busy_o));

    // R8: a finished descriptor leaves the engine idle on the next cycle
    p_idle_after_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adv_o |=> (!src_busy_o && !dst_busy_o));

endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
    import rce_pkg::*;
#(
    parameter int RING_DEPTH = 64,
    localparam int IW        = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i
);

    logic [31:0]   src_base, dst_base, src_desc, dst_desc;
    logic [IW-1:0] src_sw, dst_sw, src_hw, dst_hw;
    logic          src_en, dst_en, wb_en;
    logic          src_clr, dst_clr, adv;
    logic          src_busy, dst_busy;

    rce_regs #(.DEPTH(RING_DEPTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .src_hw_i   (src_hw),
        .dst_hw_i   (dst_hw),
        .src_busy_i (src_busy),
        .dst_busy_i (dst_busy),
        .src_base_o (src_base),
        .dst_base_o (dst_base),
        .src_sw_o   (src_sw),
        .dst_sw_o   (dst_sw),
        .src_en_o   (src_en),
        .dst_en_o   (dst_en),
        .wb_en_o    (wb_en),
        .src_clr_o  (src_clr),
        .dst_clr_o  (dst_clr)
    );

    rce_ring_ptr #(.DEPTH(RING_DEPTH)) u_src_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (src_clr),
        .adv_i       (adv),
        .base_i      (src_base),
        .idx_o       (src_hw),
        .desc_addr_o (src_desc)
    );

    rce_ring_ptr #(.DEPTH(RING_DEPTH)) u_dst_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (dst_clr),
        .adv_i       (adv),
        .base_i      (dst_base),
        .idx_o       (dst_hw),
        .desc_addr_o (dst_desc)
    );

    rce_engine #(.DEPTH(RING_DEPTH)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_en_i    (src_en),
        .dst_en_i    (dst_en),
        .wb_en_i     (wb_en),
        .abort_i     (src_clr || dst_clr),
        .src_hw_i    (src_hw),
        .src_sw_i    (src_sw),
        .dst_hw_i    (dst_hw),
        .dst_sw_i    (dst_sw),
        .src_desc_i  (src_desc),
        .dst_desc_i  (dst_desc),
        .adv_o       (adv),
        .src_busy_o  (src_busy),
        .dst_busy_o  (dst_busy),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i)
    );

    // R9: both rings step together, so their hardware indices move as a pair
    p_hw_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_clr && !dst_clr && !$stable(src_hw) && $past(!src_clr && !dst_clr))
            |-> !$stable(dst_hw));

endmodule

// File: tb/ring_copy_engine_tb.sv
module ring_copy_engine_tb;

    localparam int DEPTH = 4;
    localparam logic [31:0] SRC_RING = 32'h0000_0000;
    localparam logic [31:0] DST_RING = 32'h0000_0100;
    localparam logic [31:0] SRC_DATA = 32'h0000_1000;
    localparam logic [31:0] DST_DATA = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:4095];
    logic        bd_we = 1'b0;
    logic [11:0] bd_idx = '0;
    logic [31:0] bd_data = '0;
    int          wr_cnt = 0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ring_copy_engine #(.RING_DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    always @(posedge clk) begin
        if (bd_we) begin
            mem[bd_idx] <= bd_data;
        end else if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_idx = byte_addr[13:2]; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    function automatic logic [31:0] peek(input logic [31:0] byte_addr);
        return mem[byte_addr[13:2]];
    endfunction

    task automatic wait_dst_hw(input logic [31:0] exp, input string req);
        logic [31:0] v;
        v = 32'hFFFF_FFFF;
        for (int i = 0; i < 20000 && v != exp; i++) reg_read(12'h10C, v);
        repeat (2) @(negedge clk);
        chk(req, v, exp);
    endtask

    // clear both rings and set the bases
    task automatic fresh_rings();
        reg_write(12'h204, 32'h0);
        reg_write(12'h208, 32'h0001_0001);
        reg_write(12'h000, SRC_RING);
        reg_write(12'h100, DST_RING);
    endtask

    task automatic set_pair(input int i, input logic [31:0] src, input logic [13:0] len,
                            input logic [31:0] dst, input logic [31:0] dst_w1);
        poke(SRC_RING + 32'(16 * i), src);
        poke(SRC_RING + 32'(16 * i) + 4, {2'b00, len, 16'h0});
        poke(DST_RING + 32'(16 * i), dst);
        poke(DST_RING + 32'(16 * i) + 4, dst_w1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(12'h204, v); chk("R1 ctrl reset", v, 32'h0);
        reg_read(12'h00C, v); chk("R1 src hw reset", v, 32'h0);
        reg_read(12'h108, v); chk("R1 dst sw reset", v, 32'h0);
        reg_read(12'h104, v); chk("R1 dst count", v, 32'(DEPTH));
        chk("R1 no mem request", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(12'h000, 32'h0000_0103);
        reg_read(12'h000, v); chk("R2 base low bits", v, 32'h0000_0100);
        reg_write(12'h008, 32'h0000_00FF);
        reg_read(12'h008, v); chk("R2 sw index width", v, 32'h3);
        reg_write(12'h00C, 32'h2);
        reg_read(12'h00C, v); chk("R2 hw index read-only", v, 32'h0);
        reg_write(12'h004, 32'h9);
        reg_read(12'h004, v); chk("R2 count read-only", v, 32'(DEPTH));
        reg_write(12'h008, 32'h0);
        reg_write(12'h204, 32'h0000_047A);
        reg_read(12'h204, v); chk("R3 ctrl readback", v, 32'h0000_0470);
        reg_write(12'h204, 32'h0);
    endtask

    task automatic t_gate_and_copy();
        logic [31:0] v;
        int w0;
        fresh_rings();
        for (int k = 0; k < 4; k++) begin
            poke(SRC_DATA + 32'(4 * k), 32'hA000_0000 + 32'(k));
            poke(DST_DATA + 32'(4 * k), 32'hDEAD_0000 + 32'(k));
        end
        set_pair(0, SRC_DATA, 14'd10, DST_DATA, 32'h0);
        w0 = wr_cnt;
        reg_write(12'h008, 32'h1);
        reg_write(12'h204, 32'h45);
        repeat (40) @(negedge clk);
        reg_read(12'h00C, v); chk("R4 no free destination", v, 32'h0);
        reg_write(12'h204, 32'h41);
        reg_write(12'h108, 32'h3);
        repeat (40) @(negedge clk);
        reg_read(12'h00C, v); chk("R4 destination disabled", v, 32'h0);
        chk("R4 no writes while gated", 32'(wr_cnt - w0), 32'h0);
        reg_write(12'h204, 32'h45);
        wait_dst_hw(32'h1, "R9 dst hw after one");
        reg_read(12'h00C, v); chk("R9 src hw after one", v, 32'h1);
        chk("R5 R6 word0", peek(DST_DATA), 32'hA000_0000);
        chk("R6 word2", peek(DST_DATA + 8), 32'hA000_0002);
        chk("R6 no write past length", peek(DST_DATA + 12), 32'hDEAD_0003);
        chk("R8 write-back word", peek(DST_RING + 4), 32'h800A_0000);
    endtask

    task automatic t_zero_len();
        fresh_rings();
        poke(DST_DATA, 32'h1111_1111);
        set_pair(0, SRC_DATA, 14'd0, DST_DATA, 32'h0);
        reg_write(12'h008, 32'h1);
        reg_write(12'h108, 32'h3);
        reg_write(12'h204, 32'h45);
        wait_dst_hw(32'h1, "R6 zero length completes");
        chk("R6 zero length copies nothing", peek(DST_DATA), 32'h1111_1111);
        chk("R8 zero length write-back", peek(DST_RING + 4), 32'h8000_0000);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        fresh_rings();
        for (int i = 0; i < 4; i++) begin
            poke(SRC_DATA + 32'(16 * i), 32'hC0DE_0000 + 32'(i));
            set_pair(i, SRC_DATA + 32'(16 * i), 14'd4, DST_DATA + 32'(64 * i), 32'h0);
        end
        reg_write(12'h008, 32'h3);
        reg_write(12'h108, 32'h3);
        reg_write(12'h204, 32'h45);
        wait_dst_hw(32'h3, "R9 three descriptors");
        reg_write(12'h108, 32'h2);
        reg_write(12'h008, 32'h1);
        wait_dst_hw(32'h1, "R9 dst hw wrapped");
        reg_read(12'h00C, v); chk("R9 src hw wrapped", v, 32'h1);
        chk("R9 entry 3 data", peek(DST_DATA + 192), 32'hC0DE_0003);
        chk("R9 wrapped entry 0 data", peek(DST_DATA), 32'hC0DE_0000);
        chk("R8 entry 3 write-back", peek(DST_RING + 52), 32'h8004_0000);
    endtask

    task automatic t_no_wb();
        fresh_rings();
        poke(SRC_DATA, 32'h5A5A_0001);
        set_pair(0, SRC_DATA, 14'd4, DST_DATA, 32'h1234_5678);
        reg_write(12'h008, 32'h1);
        reg_write(12'h108, 32'h3);
        reg_write(12'h204, 32'h05);
        wait_dst_hw(32'h1, "R8 indices advance without write-back");
        chk("R8 descriptor untouched", peek(DST_RING + 4), 32'h1234_5678);
        chk("R6 data with write-back off", peek(DST_DATA), 32'h5A5A_0001);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        fresh_rings();
        set_pair(0, SRC_DATA, 14'd64, DST_DATA, 32'h0);
        reg_write(12'h008, 32'h1);
        reg_write(12'h108, 32'h3);
        reg_write(12'h204, 32'h45);
        repeat (12) @(negedge clk);
        reg_read(12'h204, v); chk("R10 busy during copy", v, 32'h4F);
        wait_dst_hw(32'h1, "R10 copy completes");
        reg_read(12'h204, v); chk("R10 idle not busy", v, 32'h45);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        fresh_rings();
        set_pair(0, SRC_DATA, 14'd64, DST_DATA, 32'h0);
        reg_write(12'h008, 32'h1);
        reg_write(12'h108, 32'h3);
        reg_write(12'h204, 32'h45);
        repeat (12) @(negedge clk);
        reg_write(12'h208, 32'h0001_0001);
        repeat (60) @(negedge clk);
        chk("R11 no write-back after abort", peek(DST_RING + 4), 32'h0);
        reg_read(12'h10C, v); chk("R11 dst hw cleared", v, 32'h0);
        reg_read(12'h008, v); chk("R11 src sw cleared", v, 32'h0);
        reg_read(12'h204, v); chk("R11 idle after abort", v, 32'h45);
    endtask

    task automatic t_clamp();
        int w0;
        fresh_rings();
        set_pair(0, SRC_DATA, 14'h3FFF, DST_DATA, 32'h0);
        reg_write(12'h008, 32'h1);
        reg_write(12'h108, 32'h3);
        w0 = wr_cnt;
        reg_write(12'h204, 32'h45);
        wait_dst_hw(32'h1, "R7 long copy completes");
        chk("R7 R12 word writes plus write-back", 32'(wr_cnt - w0), 32'd4065);
        chk("R7 reported length capped", peek(DST_RING + 4), 32'hBF80_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_gate_and_copy();
        t_zero_len();
        t_wrap();
        t_no_wb();
        t_busy();
        t_abort();
        t_clamp();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule